// File: doc/BRIEF.md
# Storage Command Request Sequencer

This block is the user-facing front end of one storage channel. A requester presents a 3-bit operation code, a 48-bit start sector and a 48-bit sector count (sectors are 512 bytes) and holds its request until the block raises busy. The block validates bulk transfers against the device capacity and the current sector-size mode, which an earlier identify step has supplied. A request that fails validation is refused without reaching the device.

A valid bulk write or read is cut into device commands of at most 256 sectors (128 KB). Each one goes out as a one-cycle issue strobe that carries the operation, the first sector and the sector count. The block then waits for a completion strobe with a 16-bit status. Administrative and flush operations go out as a single device command with a count of zero.

Every wait for a completion is bounded by a programmable cycle limit, and a limit of zero turns the bound off. Parameter faults, timeouts and bad completion status each set their own sticky bit in an error-type word. A completed shutdown parks the block in a permanent inactive state, which only reset leaves.

Top module: `stor_cmd_seq`

## Requirements
- R1: Operation codes are 000 identify, 001 shutdown, 010 write, 011 read, 100 health log and 110 flush. Codes 101 and 111 are refused: busy rises for one cycle, nothing is issued and error-type bit 0 (parameter fault) is set.
- R2: A request seen while busy is low starts an operation, and busy is high from the next cycle. Busy stays high until the whole operation ends. Requests presented while busy never start anything, and every issue strobe falls while busy is high.
- R3: A write or read whose count is zero, or whose start plus count exceeds the capacity input, is refused without any issue and sets error-type bit 0. Start plus count equal to the capacity is accepted.
- R4: A write or read of N sectors issues ceil(N/256) device commands at consecutive start sectors. Every command carries 256 sectors except the last, which carries the remainder. The same operation code is reported on every command. Each issue strobe lasts one cycle.
- R5: With the 4K-sector mode input high, a write or read whose start or count has any of its low three bits set is refused and sets error-type bit 0. With the mode low, no alignment rule applies.
- R6: When the timeout input T is nonzero, a completion that has not arrived by the T-th cycle of a wait ends the operation, sets error-type bit 1 and lowers busy. A completion in wait cycle T or earlier is accepted. T = 0 waits without limit.
- R7: A completion with nonzero status sets error-type bit 2 and ends the operation without issuing the remaining chunks. The status of the most recent completion is presented on the status output, and its bit 0 marks an invalid phase tag.
- R8: After reset, busy, issue, error flag, error-type word and inactive are all zero. The error flag is high exactly when the error-type word is nonzero, and error bits stay set until reset.
- R9: When the completion of a shutdown arrives, the block becomes inactive: busy and inactive stay high and no request is acted on until reset.
- R10: Identify, health log, flush and shutdown issue exactly one device command, with sector 0 and count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| req_i | input | 1 | Command request, held until busy is seen |
| op_i | input | 3 | Operation code |
| start_i | input | 48 | First sector |
| count_i | input | 48 | Sector count |
| busy_o | output | 1 | Operation in progress, or block inactive |
| capacity_i | input | 48 | Device capacity in sectors |
| mode4k_i | input | 1 | High when the device uses 4 KB sectors |
| tmo_limit_i | input | 32 | Completion wait limit in cycles, 0 disables |
| iss_o | output | 1 | One-cycle device command strobe |
| iss_op_o | output | 3 | Operation of the issued command |
| iss_sect_o | output | 48 | First sector of the issued command |
| iss_cnt_o | output | 9 | Sector count of the issued command |
| cpl_i | input | 1 | Device completion strobe |
| cpl_status_i | input | 16 | Completion status, bit 0 invalid phase tag |
| status_o | output | 16 | Status of the last completion |
| err_o | output | 1 | Error flag |
| err_type_o | output | 3 | Bit 0 parameter, bit 1 timeout, bit 2 completion status |
| inactive_o | output | 1 | Block locked after shutdown |

## Verification
If the sector or remaining-count registers are wrong, the fault shows at the next issue strobe as a wrong start sector or count, or as an extra or missing command. That strobe comes a few cycles after the previous completion. A wrong sequencer state shows as busy falling too early or too late, within one cycle of the completion that should have ended the operation. A wrong wait-cycle count moves the timeout bit to the wrong cycle, or lets a late completion through, at the very first wait where the limit is exercised. Error and inactive bits that fail to stick are visible on the next command boundary.

// File: rtl/stor_cmd_pkg.sv
package stor_cmd_pkg;

  localparam logic [2:0] OP_IDENT = 3'b000;
  localparam logic [2:0] OP_SHDN  = 3'b001;
  localparam logic [2:0] OP_WR    = 3'b010;
  localparam logic [2:0] OP_RD    = 3'b011;
  localparam logic [2:0] OP_HLOG  = 3'b100;
  localparam logic [2:0] OP_FLUSH = 3'b110;

  localparam int ERR_W     = 3;
  localparam int ERR_PARAM = 0;
  localparam int ERR_TMO   = 1;
  localparam int ERR_STAT  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_REFUSE,
    ST_DEAD
  } seq_state_e;

endpackage

// File: rtl/stor_req_check.sv
module stor_req_check
  import stor_cmd_pkg::*;
#(
  parameter int AW = 48
) (
  input  logic [2:0]    op,
  input  logic [AW-1:0] start,
  input  logic [AW-1:0] count,
  input  logic [AW-1:0] capacity,
  input  logic          mode4k,
  output logic          bulk,
  output logic          accept
);
  localparam int SW = AW + 1;

  logic          known;
  logic [SW-1:0] end_sect;
  logic          fits;
  logic          aligned;

  always_comb begin
    bulk     = (op == OP_WR) || (op == OP_RD);
    known    = bulk || (op == OP_IDENT) || (op == OP_SHDN) ||
               (op == OP_HLOG) || (op == OP_FLUSH);
    end_sect = {1'b0, start} + {1'b0, count};
    fits     = (count != '0) && (end_sect <= {1'b0, capacity});
    aligned  = !mode4k || ((start[2:0] == 3'b000) && (count[2:0] == 3'b000));
    accept   = known && (!bulk || (fits && aligned));
  end

endmodule

// File: rtl/stor_chunker.sv
module stor_chunker #(
  parameter int AW        = 48,
  parameter int MAX_CHUNK = 256,
  localparam int CW       = $clog2(MAX_CHUNK + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_start,
  input  logic [AW-1:0] ld_count,
  input  logic          step,
  output logic [AW-1:0] cur_sect,
  output logic [CW-1:0] chunk,
  output logic          more
);
  logic [AW-1:0] sect_q, sect_d;
  logic [AW-1:0] left_q, left_d;
  logic          en;

  always_comb begin
    if (left_q > AW'(MAX_CHUNK)) chunk = CW'(MAX_CHUNK);
    else                         chunk = left_q[CW-1:0];
    en     = load || step;
    sect_d = sect_q;
    left_d = left_q;
    if (load) begin
      sect_d = ld_start;
      left_d = ld_count;
    end else if (step) begin
      sect_d = sect_q + AW'(chunk);
      left_d = left_q - AW'(chunk);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sect_q <= '0;
      left_q <= '0;
    end else if (en) begin
      sect_q <= sect_d;
      left_q <= left_d;
    end
  end

  assign cur_sect = sect_q;
  assign more     = (left_q != '0);

endmodule

// File: rtl/stor_wait_timer.sv
module stor_wait_timer #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          en;

  always_comb begin
    en    = clr || run;
    cnt_d = clr ? '0 : cnt_q + 1'b1;
    expired = run && (limit != '0) &&
              (({1'b0, cnt_q} + {{TW{1'b0}}, 1'b1}) >= {1'b0, limit});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/stor_cmd_seq.sv
module stor_cmd_seq
  import stor_cmd_pkg::*;
#(
  parameter int AW        = 48,
  parameter int TW        = 32,
  parameter int STW       = 16,
  parameter int MAX_CHUNK = 256,
  localparam int CW       = $clog2(MAX_CHUNK + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [2:0]       op_i,
  input  logic [AW-1:0]    start_i,
  input  logic [AW-1:0]    count_i,
  output logic             busy_o,
  input  logic [AW-1:0]    capacity_i,
  input  logic             mode4k_i,
  input  logic [TW-1:0]    tmo_limit_i,
  output logic             iss_o,
  output logic [2:0]       iss_op_o,
  output logic [AW-1:0]    iss_sect_o,
  output logic [CW-1:0]    iss_cnt_o,
  input  logic             cpl_i,
  input  logic [STW-1:0]   cpl_status_i,
  output logic [STW-1:0]   status_o,
  output logic             err_o,
  output logic [ERR_W-1:0] err_type_o,
  output logic             inactive_o
);
  seq_state_e       st_q, st_d;
  logic [2:0]       op_q, op_d;
  logic [ERR_W-1:0] err_q, err_d;
  logic [STW-1:0]   stat_q;
  logic             stat_en;
  logic             op_en;

  logic             bulk, accept;
  logic             ck_load, ck_step, ck_more;
  logic [AW-1:0]    ck_sect;
  logic [CW-1:0]    ck_chunk;
  logic             tm_expired;

  stor_req_check #(.AW(AW)) u_check (
    .op       (op_i),
    .start    (start_i),
    .count    (count_i),
    .capacity (capacity_i),
    .mode4k   (mode4k_i),
    .bulk     (bulk),
    .accept   (accept)
  );

  stor_chunker #(.AW(AW), .MAX_CHUNK(MAX_CHUNK)) u_chunk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ck_load),
    .ld_start (bulk ? start_i : '0),
    .ld_count (bulk ? count_i : '0),
    .step     (ck_step),
    .cur_sect (ck_sect),
    .chunk    (ck_chunk),
    .more     (ck_more)
  );

  stor_wait_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (st_q == ST_ISSUE),
    .run     (st_q == ST_WAIT),
    .limit   (tmo_limit_i),
    .expired (tm_expired)
  );

  always_comb begin
    st_d    = st_q;
    op_d    = op_q;
    op_en   = 1'b0;
    err_d   = err_q;
    stat_en = 1'b0;
    ck_load = 1'b0;
    ck_step = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_i) begin
          if (accept) begin
            op_d    = op_i;
            op_en   = 1'b1;
            ck_load = 1'b1;
            st_d    = ST_ISSUE;
          end else begin
            err_d[ERR_PARAM] = 1'b1;
            st_d             = ST_REFUSE;
          end
        end
      end
      ST_ISSUE: begin
        ck_step = 1'b1;
        st_d    = ST_WAIT;
      end
      ST_WAIT: begin
        if (cpl_i) begin
          stat_en = 1'b1;
          if (cpl_status_i != '0) err_d[ERR_STAT] = 1'b1;
          if (op_q == OP_SHDN)            st_d = ST_DEAD;
          else if (cpl_status_i != '0)    st_d = ST_IDLE;
          else if (ck_more)               st_d = ST_ISSUE;
          else                            st_d = ST_IDLE;
        end else if (tm_expired) begin
          err_d[ERR_TMO] = 1'b1;
          st_d           = ST_IDLE;
        end
      end
      ST_REFUSE: st_d = ST_IDLE;
      ST_DEAD:   st_d = ST_DEAD;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      err_q <= '0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     op_q <= OP_IDENT;
    else if (op_en) op_q <= op_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= cpl_status_i;
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign iss_o      = (st_q == ST_ISSUE);
  assign iss_op_o   = op_q;
  assign iss_sect_o = ck_sect;
  assign iss_cnt_o  = ck_chunk;
  assign status_o   = stat_q;
  assign err_type_o = err_q;
  assign err_o      = |err_q;
  assign inactive_o = (st_q == ST_DEAD);

endmodule

// File: rtl/stor_cmd_seq_chk.sv
module stor_cmd_seq_chk #(
  parameter int AW        = 48,
  parameter int MAX_CHUNK = 256,
  localparam int CW       = $clog2(MAX_CHUNK + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_i,
  input logic          busy_o,
  input logic          mode4k_i,
  input logic          iss_o,
  input logic [2:0]    iss_op_o,
  input logic [AW-1:0] iss_sect_o,
  input logic [CW-1:0] iss_cnt_o,
  input logic          err_o,
  input logic          inactive_o
);

  p_accept_raises_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && req_i) |=> busy_o);

  p_issue_while_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_o |-> busy_o);

  p_chunk_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_o |-> (iss_cnt_o <= CW'(MAX_CHUNK)));

  p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_o |=> !iss_o);

  p_aligned_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_o && mode4k_i && iss_op_o[2:1] == 2'b01) |->
      (iss_sect_o[2:0] == 3'b000 && iss_cnt_o[2:0] == 3'b000));

  p_error_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  p_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inactive_o |=> (inactive_o && busy_o && !iss_o));

endmodule

bind stor_cmd_seq stor_cmd_seq_chk #(.AW(AW), .MAX_CHUNK(MAX_CHUNK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .busy_o     (busy_o),
  .mode4k_i   (mode4k_i),
  .iss_o      (iss_o),
  .iss_op_o   (iss_op_o),
  .iss_sect_o (iss_sect_o),
  .iss_cnt_o  (iss_cnt_o),
  .err_o      (err_o),
  .inactive_o (inactive_o)
);

// File: tb/stor_cmd_seq_test.sv
module stor_cmd_seq_test;

  logic        clk;
  logic        rst_n;
  logic        req_i;
  logic [2:0]  op_i;
  logic [47:0] start_i, count_i, capacity_i;
  logic        busy_o, mode4k_i;
  logic [31:0] tmo_limit_i;
  logic        iss_o;
  logic [2:0]  iss_op_o;
  logic [47:0] iss_sect_o;
  logic [8:0]  iss_cnt_o;
  logic        cpl_i;
  logic [15:0] cpl_status_i, status_o;
  logic        err_o;
  logic [2:0]  err_type_o;
  logic        inactive_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [2:0] exp_err;
  int issues;

  stor_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .op_i(op_i),
    .start_i(start_i), .count_i(count_i), .busy_o(busy_o),
    .capacity_i(capacity_i), .mode4k_i(mode4k_i), .tmo_limit_i(tmo_limit_i),
    .iss_o(iss_o), .iss_op_o(iss_op_o), .iss_sect_o(iss_sect_o),
    .iss_cnt_o(iss_cnt_o), .cpl_i(cpl_i), .cpl_status_i(cpl_status_i),
    .status_o(status_o), .err_o(err_o), .err_type_o(err_type_o),
    .inactive_o(inactive_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // dly: wait cycle in which the completion is given; 0 means never answer
  task automatic run_cmd(input logic [2:0] op, input logic [47:0] a, input logic [47:0] l,
                         input int dly, input logic [15:0] st, input bit bulk_exp);
    logic [47:0] esect, eleft;
    int guard;
    esect = bulk_exp ? a : 48'd0;
    eleft = bulk_exp ? l : 48'd0;
    issues = 0;
    @(negedge clk);
    req_i = 1'b1; op_i = op; start_i = a; count_i = l;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!busy_o && guard < 50);
    req_i = 1'b0;
    guard = 0;
    while (busy_o && !inactive_o && guard < 20000) begin
      guard++;
      if (iss_o) begin
        logic [47:0] ecnt;
        ecnt = (eleft > 48'd256) ? 48'd256 : eleft;
        issues++;
        chk(iss_sect_o == esect, "R4 sector", iss_sect_o, esect);
        chk(48'(iss_cnt_o) == ecnt, "R4 count", iss_cnt_o, ecnt);
        chk(iss_op_o == op, "R4 op", iss_op_o, op);
        esect = esect + ecnt;
        eleft = eleft - ecnt;
        if (dly > 0) begin
          repeat (dly) @(negedge clk);
          cpl_i = 1'b1; cpl_status_i = st;
          @(negedge clk);
          cpl_i = 1'b0; cpl_status_i = '0;
        end else @(negedge clk);
      end else @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    exp_err = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    req_i = 0; op_i = 0; start_i = 0; count_i = 0; capacity_i = 48'd4096;
    mode4k_i = 0; tmo_limit_i = 0; cpl_i = 0; cpl_status_i = 0;
    do_reset();
    // R8 reset state
    chk(!busy_o && !iss_o && !err_o && err_type_o == 0 && !inactive_o,
        "R8 reset state", {busy_o, iss_o, err_o, err_type_o, inactive_o}, 0);

    // R4 R2: sweep write/read lengths, 512-byte mode
    for (int l = 1; l <= 600; l++) begin
      logic [47:0] a;
      int nexp;
      a = 48'((l * 7) % 97);
      nexp = (l + 255) / 256;
      run_cmd((l % 2) ? 3'b010 : 3'b011, a, 48'(l), 1, 16'h0, 1'b1);
      chk(issues == nexp, "R4 chunk total", issues, nexp);
      chk(!busy_o, "R2 busy falls", busy_o, 0);
      chk(err_type_o == exp_err, "R8 error word", err_type_o, exp_err);
    end

    // R5: alignment sweep in 4K mode
    mode4k_i = 1'b1;
    for (int a = 0; a < 16; a++) begin
      for (int l = 1; l <= 16; l++) begin
        bit good;
        good = (a % 8 == 0) && (l % 8 == 0);
        run_cmd(3'b010, 48'(a), 48'(l), 1, 16'h0, good);
        if (!good) exp_err[0] = 1'b1;
        chk(issues == (good ? 1 : 0), "R5 alignment", issues, good ? 1 : 0);
        chk(err_type_o == exp_err, "R5 error word", err_type_o, exp_err);
      end
    end
    mode4k_i = 1'b0;

    do_reset();
    // R3: capacity bounds
    run_cmd(3'b011, 48'd3596, 48'd500, 1, 16'h0, 1'b1);
    chk(issues == 2 && err_type_o == 0, "R3 exact fit", issues, 2);
    run_cmd(3'b011, 48'd3597, 48'd500, 1, 16'h0, 1'b0);
    chk(issues == 0, "R3 overrun refused", issues, 0);
    chk(err_type_o == 3'b001 && err_o, "R3 param bit", err_type_o, 1);
    run_cmd(3'b010, 48'd0, 48'd0, 1, 16'h0, 1'b0);
    chk(issues == 0, "R3 zero length refused", issues, 0);

    // R1: reserved codes
    do_reset();
    run_cmd(3'b101, 48'd0, 48'd8, 1, 16'h0, 1'b0);
    chk(issues == 0 && err_type_o == 3'b001, "R1 code 101 refused", err_type_o, 1);
    run_cmd(3'b111, 48'd0, 48'd8, 1, 16'h0, 1'b0);
    chk(issues == 0, "R1 code 111 refused", issues, 0);

    // R10: single-command operations
    do_reset();
    run_cmd(3'b000, 48'd5, 48'd9, 2, 16'h0, 1'b0);
    chk(issues == 1, "R10 identify one command", issues, 1);
    run_cmd(3'b100, 48'd5, 48'd9, 2, 16'h0, 1'b0);
    chk(issues == 1, "R10 health log one command", issues, 1);
    run_cmd(3'b110, 48'd5, 48'd9, 2, 16'h0, 1'b0);
    chk(issues == 1 && err_type_o == 0, "R10 flush one command", issues, 1);

    // R6: timeout
    tmo_limit_i = 32'd5;
    run_cmd(3'b110, 48'd0, 48'd0, 5, 16'h0, 1'b0);
    chk(err_type_o == 0, "R6 completion at limit accepted", err_type_o, 0);
    run_cmd(3'b010, 48'd0, 48'd300, 0, 16'h0, 1'b1);
    chk(issues == 1 && !busy_o, "R6 abort on timeout", issues, 1);
    chk(err_type_o == 3'b010, "R6 timeout bit", err_type_o, 2);
    do_reset();
    tmo_limit_i = 32'd0;
    run_cmd(3'b011, 48'd0, 48'd10, 40, 16'h0, 1'b1);
    chk(err_type_o == 0 && issues == 1, "R6 zero limit waits", err_type_o, 0);

    // R7: bad status aborts remaining chunks
    run_cmd(3'b011, 48'd0, 48'd600, 1, 16'h0001, 1'b1);
    chk(issues == 1, "R7 abort remaining", issues, 1);
    chk(status_o == 16'h0001, "R7 status export", status_o, 1);
    chk(err_type_o == 3'b100 && err_o, "R7 status bit", err_type_o, 4);
    run_cmd(3'b010, 48'd0, 48'd4, 1, 16'h0, 1'b1);
    chk(err_o && status_o == 0, "R8 flag stays set", err_o, 1);

    // R9: shutdown locks
    do_reset();
    run_cmd(3'b001, 48'd0, 48'd0, 3, 16'h0, 1'b0);
    @(negedge clk);
    chk(inactive_o && busy_o, "R9 inactive", inactive_o, 1);
    req_i = 1'b1; op_i = 3'b010; start_i = 0; count_i = 8;
    begin
      int seen;
      seen = 0;
      repeat (20) begin
        @(negedge clk);
        if (iss_o) seen++;
      end
      chk(seen == 0, "R9 requests ignored", seen, 0);
    end
    req_i = 1'b0;
    chk(inactive_o && busy_o, "R9 still inactive", inactive_o, 1);
    do_reset();
    chk(!inactive_o && !busy_o && !err_o, "R8 reset leaves inactive", inactive_o, 0);
    run_cmd(3'b010, 48'd16, 48'd20, 1, 16'h0, 1'b1);
    chk(issues == 1, "R9 live after reset", issues, 1);

    finish_run();
  end

endmodule